// File: doc/BRIEF.md
# Oscillator Status and Output Control

This block keeps the three status and control bits of a real-time clock that depend on its 32.768 kHz time base. The three bits are a sticky oscillator-failure flag, a stop bit that halts the oscillator, and an output-level bit that drives an open-drain pin. The block watches the slow time base with a timeout counter that runs on the fast system clock. If no rising edge arrives within a set number of system clocks, it treats the oscillator as missing and raises the failure flag.

A second counter measures how long the oscillator has run without interruption. Software may clear the failure flag only once that run time reaches a configured number of oscillator periods; at 32.768 kHz, four seconds is the default. A clear attempted earlier is dropped. The bits sit at bit 7 of register addresses 0 (stop), 1 (failure flag) and 7 (output level), and are written and read through a single-bit slice of the register bus.

Top module: `osc_status_ctl`

## Requirements
- R1: After reset the failure flag is 1, the stop bit is 0 and the output-level bit is 1, so `osc_enable` is 1 and `out_drive_low` is 0.
- R2: A write to address 0 loads the stop bit from `wr_bit7`; `osc_enable` is the inverse of the stop bit.
- R3: A write of 1 to the stop bit sets the failure flag at the same clock edge that sets the stop bit.
- R4: When no rising edge appears on `osc_in` for `TIMEOUT_CLKS` system clocks, the failure flag is 1 no later than `TIMEOUT_CLKS`+4 clock edges after the clock in which the last rising edge was driven.
- R5: The failure flag is sticky. It stays 1 until an honoured clear, and a write of 1 to address 1 sets it.
- R6: A write of 0 to address 1 clears the failure flag only if `RUN_EDGES` rising edges of `osc_in` have been counted since the last restart of the run counter. An earlier clear is ignored and the flag stays 1.
- R7: When a stop detection and an honoured clear fall in the same cycle, the set wins and the flag stays 1.
- R8: A write to address 7 loads the output-level bit. `out_drive_low` is 1 exactly when that bit is 0.
- R9: `rd_bit7` returns the stop bit for address 0, the failure flag for address 1 and the output level for address 7, and returns 0 for any other address.
- R10: Writes to addresses 2 to 6 change none of the three bits.
- R11: The run counter restarts from zero while a stop is detected or the stop bit is 1. Run time accumulated before a stop does not count toward a later clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | 32.768 kHz time base, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_bit7 | input | 1 | Bit 7 of the write data |
| rd_addr | input | 3 | Register read address |
| rd_bit7 | output | 1 | Bit 7 of the addressed register |
| osc_enable | output | 1 | Oscillator run enable (inverse of the stop bit) |
| fail_flag | output | 1 | Oscillator failure flag |
| stop_bit | output | 1 | Stop bit |
| out_drive_low | output | 1 | Open-drain pull-down enable for the output pin |

## Verification
The critical collision occurs when the oscillator is declared missing in the same cycle that software clears the flag. The run counter has not yet dropped in that cycle, so the clear would otherwise be honoured. The bench runs the oscillator long enough for clears to be accepted, then drives a final rising edge itself and holds a clear write on the bus in every cycle while the time base stays silent. It samples the flag exactly `TIMEOUT_CLKS`+4 edges later and expects 1; a design in which the clear won that cycle would still read 0 at that sample.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

    localparam int REG_ADDR_W = 3;

    typedef logic [REG_ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADDR_STOP = 3'd0;
    localparam reg_addr_t ADDR_FAIL = 3'd1;
    localparam reg_addr_t ADDR_CTRL = 3'd7;

    typedef struct packed {
        logic stop;
        logic fail;
        logic out_lvl;
    } status_t;

    typedef struct packed {
        logic      en;
        reg_addr_t addr;
        logic      bit7;
    } wr_req_t;

    function automatic logic wr_hits(wr_req_t w, reg_addr_t a);
        return w.en && (w.addr == a);
    endfunction

    function automatic logic read_bit7(status_t s, reg_addr_t a);
        case (a)
            ADDR_STOP: return s.stop;
            ADDR_FAIL: return s.fail;
            ADDR_CTRL: return s.out_lvl;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[LAST:0], async_in};
    end

    assign rise = shreg[LAST] & ~shreg[SYNC_STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise) else $error("rise pulse longer than one cycle"); // R4
endmodule

// File: rtl/osc_stop_watch.sv
module osc_stop_watch #(
    parameter int TIMEOUT_CLKS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output logic missing
);
    localparam int CW = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CLKS);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst)                   idle_cnt <= '0;
        else if (rise)             idle_cnt <= '0;
        else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign missing = (idle_cnt == LIMIT);

    AST_EDGE_REVIVES: assert property (@(posedge clk) disable iff (rst)
        rise |=> !missing) else $error("edge did not clear stop detection"); // R4
    AST_MISSING_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (missing && !rise) |=> missing) else $error("stop detection dropped without edge"); // R4
endmodule

// File: rtl/osc_run_timer.sv
module osc_run_timer #(
    parameter int RUN_EDGES = 131072
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic restart,
    output logic run_ok
);
    localparam int RW = $clog2(RUN_EDGES + 1);
    localparam logic [RW-1:0] GOAL = RW'(RUN_EDGES);

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)              run_cnt <= '0;
        else if (rise && run_cnt != GOAL) run_cnt <= run_cnt + 1'b1;
    end

    assign run_ok = (run_cnt == GOAL);

    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
        restart |=> !run_ok) else $error("run time survived a restart"); // R11
endmodule

// File: rtl/osc_status_ctl.sv
module osc_status_ctl
    import osc_ctl_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 1024,
    parameter int RUN_EDGES    = 131072,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_in,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic       wr_bit7,
    input  logic [2:0] rd_addr,
    output logic       rd_bit7,
    output logic       osc_enable,
    output logic       fail_flag,
    output logic       stop_bit,
    output logic       out_drive_low
);
    status_t stat_q;
    status_t stat_d;
    wr_req_t wreq;
    logic    rise;
    logic    missing;
    logic    run_ok;
    logic    restart;
    logic    stop_set;
    logic    fail_set;
    logic    fail_clr;

    assign wreq = '{en: wr_en, addr: wr_addr, bit7: wr_bit7};

    osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(osc_in), .rise(rise)
    );

    osc_stop_watch #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_watch (
        .clk(clk), .rst(rst), .rise(rise), .missing(missing)
    );

    assign restart = missing | stat_q.stop;

    osc_run_timer #(.RUN_EDGES(RUN_EDGES)) u_timer (
        .clk(clk), .rst(rst), .rise(rise), .restart(restart), .run_ok(run_ok)
    );

    always_comb begin
        stop_set = wr_hits(wreq, ADDR_STOP) && wreq.bit7;
        fail_set = restart || stop_set || (wr_hits(wreq, ADDR_FAIL) && wreq.bit7);
        fail_clr = wr_hits(wreq, ADDR_FAIL) && !wreq.bit7 && run_ok;
        stat_d   = stat_q;
        if (wr_hits(wreq, ADDR_STOP)) stat_d.stop    = wreq.bit7;
        if (wr_hits(wreq, ADDR_CTRL)) stat_d.out_lvl = wreq.bit7;
        if (fail_set)                 stat_d.fail    = 1'b1;
        else if (fail_clr)            stat_d.fail    = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '{stop: 1'b0, fail: 1'b1, out_lvl: 1'b1};
        else     stat_q <= stat_d;
    end

    assign rd_bit7       = read_bit7(stat_q, rd_addr);
    assign osc_enable    = ~stat_q.stop;
    assign fail_flag     = stat_q.fail;
    assign stop_bit      = stat_q.stop;
    assign out_drive_low = ~stat_q.out_lvl;

    AST_STOP_SETS_FAIL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_STOP && wr_bit7) |=> fail_flag) else $error("stop write left flag clear"); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        missing |=> fail_flag) else $error("clear beat stop detection"); // R7
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !(wr_en && wr_addr == ADDR_FAIL)) |=> fail_flag) else $error("flag dropped without write"); // R5
    AST_CLEAR_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(fail_flag) |-> $past(run_ok)) else $error("flag cleared before run time"); // R6
    AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr inside {[3'd2:3'd6]}) |=> ($stable(stop_bit) && $stable(out_drive_low))) else $error("write to other address changed a bit"); // R10
endmodule

// File: tb/osc_status_ctl_bench.sv
module osc_status_ctl_bench;
    localparam int CLK_P   = 10;
    localparam int TMO     = 20;
    localparam int RUN     = 8;
    localparam int HALF    = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic       wr_bit7 = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic       rd_bit7, osc_enable, fail_flag, stop_bit, out_drive_low;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    int phase  = 0;
    logic osc_run = 1'b0;
    logic done = 1'b0;
    logic exp_stop, exp_fail, exp_out;

    osc_status_ctl #(.TIMEOUT_CLKS(TMO), .RUN_EDGES(RUN), .SYNC_STAGES(2)) u_osc_status_ctl (
        .clk(clk), .rst(rst), .osc_in(osc_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_bit7(wr_bit7), .rd_addr(rd_addr), .rd_bit7(rd_bit7), .osc_enable(osc_enable),
        .fail_flag(fail_flag), .stop_bit(stop_bit), .out_drive_low(out_drive_low)
    );

    always #(CLK_P/2) clk = ~clk;

    // Oscillator model: runs only when enabled by the bench and by the block.
    always @(negedge clk) begin
        if (osc_run && osc_enable) begin
            phase = phase + 1;
            if (phase >= HALF) begin
                phase = 0;
                if (!osc_in) rises = rises + 1;
                osc_in = ~osc_in;
            end
        end
    end

    function automatic logic exp_read(input logic [2:0] a, input logic s,
                                      input logic f, input logic o);
        if (a == 3'd0) return s;
        if (a == 3'd1) return f;
        if (a == 3'd7) return o;
        return 1'b0;
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_bit7 = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        int target;
        target = rises + n;
        while (rises < target) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        chk(fail_flag, 1'b1, "R1 fail");
        chk(stop_bit, 1'b0, "R1 stop");
        chk(osc_enable, 1'b1, "R1 enable");
        chk(out_drive_low, 1'b0, "R1 pin");
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); #1;
            chk(rd_bit7, exp_read(3'(a), 1'b0, 1'b1, 1'b1), "R1 R9 read");
        end

        // R6: early clear ignored, late clear honoured
        repeat (TMO + 10) @(negedge clk);
        osc_run = 1'b1;
        wait_rises(RUN - 3);
        wr(3'd1, 1'b0);
        chk(fail_flag, 1'b1, "R6 early clear");
        wait_rises(RUN);
        wr(3'd1, 1'b0);
        chk(fail_flag, 1'b0, "R6 late clear");

        // R8 R9 R10 random writes to addresses 2..7
        exp_stop = 1'b0; exp_fail = 1'b0; exp_out = 1'b1;
        for (int i = 0; i < 150; i++) begin
            logic [2:0] a;
            logic b;
            a = 3'(2 + ($urandom % 6));
            b = 1'($urandom % 2);
            wr(a, b);
            if (a == 3'd7) exp_out = b;
            chk(out_drive_low, ~exp_out, "R8 pin");
            chk(stop_bit, exp_stop, "R10 stop");
            chk(fail_flag, exp_fail, "R10 fail");
            rd_addr = 3'($urandom % 8); #1;
            chk(rd_bit7, exp_read(rd_addr, exp_stop, exp_fail, exp_out), "R9 read");
        end

        // R5 write one sets, clear after run time
        wr(3'd1, 1'b1);
        chk(fail_flag, 1'b1, "R5 set by write");
        repeat (5) @(negedge clk);
        chk(fail_flag, 1'b1, "R5 sticky");
        wr(3'd1, 1'b0);
        chk(fail_flag, 1'b0, "R5 clear");

        // R2 R3 R11 stop bit
        wr(3'd0, 1'b1);
        chk(fail_flag, 1'b1, "R3 stop sets flag");
        chk(stop_bit, 1'b1, "R2 stop");
        chk(osc_enable, 1'b0, "R2 enable");
        rd_addr = 3'd0; #1;
        chk(rd_bit7, 1'b1, "R9 read stop");
        repeat (TMO + 5) @(negedge clk);
        wr(3'd0, 1'b0);
        chk(osc_enable, 1'b1, "R2 enable back");
        wait_rises(RUN - 3);
        wr(3'd1, 1'b0);
        chk(fail_flag, 1'b1, "R11 old run time discarded");
        wait_rises(RUN + 2);
        wr(3'd1, 1'b0);
        chk(fail_flag, 1'b0, "R11 clear after fresh run");

        // R4 R7: silent oscillator with a clear on the bus every cycle
        osc_run = 1'b0;
        @(negedge clk);
        osc_in = 1'b0;
        wr_en = 1'b1; wr_addr = 3'd1; wr_bit7 = 1'b0;
        repeat (3) @(negedge clk);
        chk(fail_flag, 1'b0, "R6 clears still honoured");
        osc_in = 1'b1;
        repeat (TMO + 4) @(posedge clk);
        @(negedge clk);
        chk(fail_flag, 1'b1, "R4 R7 stop detect wins");
        repeat (TMO) @(negedge clk);
        chk(fail_flag, 1'b1, "R5 held while silent");
        wr_en = 1'b0;

        // recovery
        phase = 0;
        osc_run = 1'b1;
        wait_rises(RUN + 4);
        wr(3'd1, 1'b0);
        chk(fail_flag, 1'b0, "R6 recovery clear");

        done = 1'b1;
        summary();
    end
endmodule